// File: doc/BRIEF.md
# ARX 4x4 Word Permutation Core

This block is an iterative, keyless permutation engine. It holds a state of sixteen words, each `WORD_W` bits wide, viewed as a 4x4 matrix with word i at row i/4 and column i%4. A single-cycle start pulse loads a complete state and a round count. The core then mixes the state round by round and raises a one-cycle done pulse when the permuted state is ready at its output. The output stays unchanged until a later start is accepted.

Each round has two half-rounds. The first is a column step and the second is a diagonal step. Every step evaluates four copies of the quarter-function side by side, one on each disjoint group of four words, so one half-round completes per clock. The quarter-function has no integer adders. In place of addition it uses the carry-free term H(x,y) = x ^ y ^ ((x & y) << 1), followed by XOR and fixed right rotations. A controlling block, such as a sponge-mode engine, is expected to drive the state in, wait for done, and read the state back.

The state machine has three states. ST_IDLE waits for an accepted start and moves to ST_COL (transition "accept"). ST_COL always moves to ST_DIAG (transition "col_done"). ST_DIAG moves back to ST_COL while more rounds remain (transition "next_round"). After the last round it moves to ST_IDLE and pulses done (transition "finish").

Top module: `arx_perm_core`

## Requirements
- R1: After reset, busy and done are 0 and state_out is all zero.
- R2: A start is accepted only in ST_IDLE with a nonzero rounds_in. On acceptance the core latches state_in and rounds_in, and busy is 1 from the next cycle.
- R3: H(x,y) = x ^ y ^ ((x & y) << 1). The quarter-function on (a,b,c,d) runs these steps in order: a=H(a,b); d=ROR(a^d,r0); c=H(c,d); b=ROR(c^b,r1); a=H(a,b); d=ROR(a^d,r2); c=H(c,d); b=ROR(c^b,r3).
- R4: A round first applies the quarter-function to the column groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). It then applies it to the diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). After l rounds the output equals this reference permutation.
- R5: The rotation amounts (r0,r1,r2,r3) are (8,11,16,31) when WORD_W is 32 and (8,19,40,63) when WORD_W is 64.
- R6: done is high for exactly one cycle, exactly 2*l clock edges after the accepting edge. busy falls on the same edge that raises done.
- R7: A start asserted while busy is 1 is ignored. This holds on the last busy cycle too. The result and the latency are those of the run already in progress.
- R8: A start with rounds_in equal to 0 is ignored. busy stays 0 and state_out keeps its value.
- R9: While idle, state_out holds the last result until the next accepted start.
- R10: Word i of the state occupies bits [i*WORD_W +: WORD_W] of state_in and state_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load a state and begin a run |
| rounds_in | input | CNT_W | Number of rounds, 1 to 63 |
| state_in | input | 16*WORD_W | State to permute, word i at bits [i*WORD_W +: WORD_W] |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| state_out | output | 16*WORD_W | Current state register, which holds the result when idle |

## Verification
The hardest situation to reach is a start that arrives on the final busy cycle. That is the ST_DIAG cycle in which the core is already heading back to idle, and a wrong priority there would restart the run or corrupt its result. The stimulus steers the run with a cycle counter. It raises start with a different state at chosen offsets, including the offset equal to 2*l, and then checks that both the result and the latency still belong to the original run. Random states with random round counts exercise the mixing. Directed all-zero and all-ones states push carry-like chains through every bit of H.

// File: rtl/arx_perm_pkg.sv
package arx_perm_pkg;

    localparam int NWORDS = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COL  = 2'd1,
        ST_DIAG = 2'd2
    } perm_fsm_t;

    // Rotation amount idx (0..3) for a given word width
    function automatic int rot_amt(input int w, input int idx);
        int r;
        if (w == 64) begin
            case (idx)
                0: r = 8;
                1: r = 19;
                2: r = 40;
                default: r = 63;
            endcase
        end else begin
            case (idx)
                0: r = 8;
                1: r = 11;
                2: r = 16;
                default: r = 31;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/arx_quarter.sv
module arx_quarter #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    input  logic [WORD_W-1:0] d_i,
    output logic [WORD_W-1:0] a_o,
    output logic [WORD_W-1:0] b_o,
    output logic [WORD_W-1:0] c_o,
    output logic [WORD_W-1:0] d_o
);
    localparam int ROT0 = arx_perm_pkg::rot_amt(WORD_W, 0);
    localparam int ROT1 = arx_perm_pkg::rot_amt(WORD_W, 1);
    localparam int ROT2 = arx_perm_pkg::rot_amt(WORD_W, 2);
    localparam int ROT3 = arx_perm_pkg::rot_amt(WORD_W, 3);

    function automatic logic [WORD_W-1:0] mix(input logic [WORD_W-1:0] x,
                                              input logic [WORD_W-1:0] y);
        return x ^ y ^ ((x & y) << 1);
    endfunction

    function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x,
                                               input int r);
        return (x >> r) | (x << (WORD_W - r));
    endfunction

    logic [WORD_W-1:0] a1, d1, c1, b1, a2, d2, c2, b2;

    always_comb begin
        a1 = mix(a_i, b_i);
        d1 = rotr(a1 ^ d_i, ROT0);
        c1 = mix(c_i, d1);
        b1 = rotr(c1 ^ b_i, ROT1);
        a2 = mix(a1, b1);
        d2 = rotr(a2 ^ d1, ROT2);
        c2 = mix(c1, d2);
        b2 = rotr(c2 ^ b1, ROT3);
    end

    assign a_o = a2;
    assign b_o = b2;
    assign c_o = c2;
    assign d_o = d2;
endmodule

// File: rtl/arx_half_step.sv
module arx_half_step #(
    parameter int WORD_W = 32
) (
    input  logic              diag_i,
    input  logic [WORD_W-1:0] words_i [arx_perm_pkg::NWORDS],
    output logic [WORD_W-1:0] words_o [arx_perm_pkg::NWORDS]
);
    logic [WORD_W-1:0] qa [4];
    logic [WORD_W-1:0] qb [4];
    logic [WORD_W-1:0] qc [4];
    logic [WORD_W-1:0] qd [4];

    // Group j: row 0 column j; rows 1..3 shifted by r*j-offset when diagonal
    for (genvar j = 0; j < 4; j++) begin : g_grp
        localparam int IB = 4  + ((j + 1) % 4);
        localparam int IC = 8  + ((j + 2) % 4);
        localparam int ID = 12 + ((j + 3) % 4);
        arx_quarter #(.WORD_W(WORD_W)) u_q (
            .a_i(words_i[j]),
            .b_i(diag_i ? words_i[IB] : words_i[4 + j]),
            .c_i(diag_i ? words_i[IC] : words_i[8 + j]),
            .d_i(diag_i ? words_i[ID] : words_i[12 + j]),
            .a_o(qa[j]),
            .b_o(qb[j]),
            .c_o(qc[j]),
            .d_o(qd[j])
        );
    end

    // Scatter group results back to matrix positions
    for (genvar k = 0; k < 4; k++) begin : g_out
        assign words_o[k]      = qa[k];
        assign words_o[4 + k]  = diag_i ? qb[(k + 3) % 4] : qb[k];
        assign words_o[8 + k]  = diag_i ? qc[(k + 2) % 4] : qc[k];
        assign words_o[12 + k] = diag_i ? qd[(k + 1) % 4] : qd[k];
    end
endmodule

// File: rtl/arx_perm_core.sv
module arx_perm_core
    import arx_perm_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CNT_W-1:0]           rounds_in,
    input  logic [NWORDS*WORD_W-1:0]   state_in,
    output logic                       busy,
    output logic                       done,
    output logic [NWORDS*WORD_W-1:0]   state_out
);
    perm_fsm_t         fsm_q, fsm_d;
    logic [CNT_W-1:0]  left_q;
    logic              done_q;
    logic              accept;
    logic              last_round;
    logic [WORD_W-1:0] st_q    [NWORDS];
    logic [WORD_W-1:0] step_w  [NWORDS];

    assign accept     = (fsm_q == ST_IDLE) && start && (rounds_in != '0);
    assign last_round = (left_q == CNT_W'(1));

    arx_half_step #(.WORD_W(WORD_W)) u_step (
        .diag_i  (fsm_q == ST_DIAG),
        .words_i (st_q),
        .words_o (step_w)
    );

    // Next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE: if (accept) fsm_d = ST_COL;
            ST_COL:  fsm_d = ST_DIAG;
            ST_DIAG: fsm_d = last_round ? ST_IDLE : ST_COL;
            default: fsm_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < NWORDS; i++) st_q[i] <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (fsm_q)
                ST_IDLE: begin
                    if (accept) begin
                        left_q <= rounds_in;
                        for (int i = 0; i < NWORDS; i++)
                            st_q[i] <= state_in[i*WORD_W +: WORD_W];
                    end
                end
                ST_COL: begin
                    for (int i = 0; i < NWORDS; i++) st_q[i] <= step_w[i];
                end
                ST_DIAG: begin
                    for (int i = 0; i < NWORDS; i++) st_q[i] <= step_w[i];
                    if (last_round) done_q <= 1'b1;
                    else            left_q <= left_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NWORDS; i++) begin : g_pack
        assign state_out[i*WORD_W +: WORD_W] = st_q[i];
    end

    assign busy = (fsm_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/arx_perm_chk.sv
module arx_perm_chk #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic [CNT_W-1:0]          rounds_in,
    input logic [16*WORD_W-1:0]      state_in,
    input logic                      busy,
    input logic                      done,
    input logic [16*WORD_W-1:0]      state_out
);
    logic [CNT_W-1:0] lat_q;
    logic [CNT_W+1:0] cyc_q;
    logic             acc;
    logic [16*WORD_W-1:0] unused_in;

    assign acc       = !busy && start && (rounds_in != '0);
    assign unused_in = state_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            cyc_q <= '0;
        end else if (acc) begin
            lat_q <= rounds_in;
            cyc_q <= '0;
        end else if (busy) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_q == {1'b0, lat_q, 1'b0}));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R8
    zero_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && rounds_in == '0) |=> !busy);

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !acc) |=> $stable(state_out));
endmodule

bind arx_perm_core arx_perm_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/arx_perm_core_bench.sv
module arx_perm_core_bench;
    localparam int W  = 32;
    localparam int SW = 16 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [5:0]    rounds_in = '0;
    logic [SW-1:0] state_in = '0;
    logic          busy, done;
    logic [SW-1:0] state_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    arx_perm_core u_arx_perm_core (
        .clk(clk), .rst_n(rst_n), .start(start), .rounds_in(rounds_in),
        .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
    );

    task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model (R3, R4, R5 with W=32)
    function automatic logic [31:0] h_f(input logic [31:0] x, input logic [31:0] y);
        return x ^ y ^ ((x & y) << 1);
    endfunction

    function automatic logic [31:0] ror_f(input logic [31:0] x, input int r);
        return (x >> r) | (x << (32 - r));
    endfunction

    function automatic logic [127:0] qf(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input logic [31:0] d);
        a = h_f(a, b); d = ror_f(a ^ d, 8);
        c = h_f(c, d); b = ror_f(c ^ b, 11);
        a = h_f(a, b); d = ror_f(a ^ d, 16);
        c = h_f(c, d); b = ror_f(c ^ b, 31);
        return {a, b, c, d};
    endfunction

    function automatic logic [SW-1:0] ref_perm(input logic [SW-1:0] st, input int rnd);
        logic [31:0] v [16];
        logic [127:0] q;
        int ix [8][4];
        for (int j = 0; j < 4; j++) begin
            ix[j] = '{j, 4 + j, 8 + j, 12 + j};
            ix[4 + j] = '{j, 4 + (j + 1) % 4, 8 + (j + 2) % 4, 12 + (j + 3) % 4};
        end
        for (int i = 0; i < 16; i++) v[i] = st[i*32 +: 32];
        for (int r = 0; r < rnd; r++) begin
            for (int g = 0; g < 8; g++) begin
                q = qf(v[ix[g][0]], v[ix[g][1]], v[ix[g][2]], v[ix[g][3]]);
                v[ix[g][0]] = q[127:96];
                v[ix[g][1]] = q[95:64];
                v[ix[g][2]] = q[63:32];
                v[ix[g][3]] = q[31:0];
            end
        end
        for (int i = 0; i < 16; i++) st[i*32 +: 32] = v[i];
        return st;
    endfunction

    function automatic logic [SW-1:0] rand_state();
        logic [SW-1:0] s;
        for (int i = 0; i < 16; i++) s[i*32 +: 32] = $urandom;
        return s;
    endfunction

    // Run one permutation; inject>0 raises start with another state at that cycle
    task automatic run(input logic [SW-1:0] st, input int rnd, input int inject,
                       input string tag);
        int cnt;
        logic [SW-1:0] exp;
        int done_cycles;
        exp = ref_perm(st, rnd);
        @(negedge clk);
        start = 1'b1; state_in = st; rounds_in = 6'(rnd);
        @(negedge clk);
        start = 1'b0; state_in = ~st;
        chk(busy == 1'b1, {"R2 busy after accept ", tag}, SW'(busy), SW'(1));
        cnt = 1;
        while (!done && cnt < 400) begin
            @(negedge clk);
            cnt++;
            start = (inject > 0 && cnt == inject);
            rounds_in = start ? 6'd2 : 6'(rnd);
        end
        start = 1'b0;
        chk((cnt - 1) == 2 * rnd, {"R6 latency ", tag}, SW'(cnt - 1), SW'(2 * rnd));
        chk(state_out == exp, {"R4 result ", tag}, state_out, exp);
        chk(busy == 1'b0, {"R6 busy low with done ", tag}, SW'(busy), SW'(0));
        done_cycles = 0;
        @(negedge clk);
        if (done) done_cycles++;
        chk(done_cycles == 0, {"R6 single pulse ", tag}, SW'(done_cycles), SW'(0));
        if (inject > 0)
            chk(state_out == exp, {"R7 start during busy ignored ", tag}, state_out, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [SW-1:0] s, held;
        void'($urandom(32'h5eed_0a7c));
        repeat (3) @(negedge clk);
        // R1
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset",
            SW'({busy, done}), SW'(0));
        chk(state_out == '0, "R1 state after reset", state_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // All-zero state stays zero; all-ones exercises carry-like term (R3)
        run('0, 1, 0, "zero l=1");
        chk(state_out == '0, "R3 zero fixed point", state_out, '0);
        run('1, 4, 0, "ones l=4");

        // R10: a single word marker, one round, checked via model word positions
        s = '0; s[5*32 +: 32] = 32'h0000_0001;
        run(s, 1, 0, "single word l=1");

        // Standard and extreme round counts (R4, R5)
        run(rand_state(), 4, 0, "rand l=4");
        run(rand_state(), 6, 0, "rand l=6");
        run(rand_state(), 63, 0, "rand l=63");

        // R7: start mid-run and on final busy cycle
        run(rand_state(), 4, 3, "inject mid");
        run(rand_state(), 3, 6, "inject last");
        run(rand_state(), 1, 2, "inject last l=1");

        // R8: zero rounds ignored, R9: output held while idle
        held = state_out;
        @(negedge clk);
        start = 1'b1; rounds_in = 6'd0; state_in = rand_state();
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R8 zero rounds no busy", SW'(busy), SW'(0));
        chk(state_out == held, "R8 zero rounds state kept", state_out, held);
        repeat (10) @(negedge clk);
        chk(state_out == held, "R9 idle hold", state_out, held);
        chk(done == 1'b0, "R9 no spurious done", SW'(done), SW'(0));

        // Random mix
        for (int k = 0; k < 20; k++) begin
            int rr;
            rr = 1 + int'($urandom_range(0, 7));
            run(rand_state(), rr, 0, "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule